// File: doc/BRIEF.md
# Indirect Sideband Register Access Bridge

This block is a host-side mailbox that reaches a private internal register space through three 32-bit host words. Software places a target address and, for stores, a payload word into two of them. It places an opcode and a route selector into the control word, then rings a doorbell bit. The bridge checks the route key and the opcode. It then runs a single request/acknowledge exchange on an internal port and records the completion code. For loads it also records the returned word, and finally drops the busy flag.

The host side is a plain word-wide write port with byte enables and a combinational read mux. The internal side carries address, opcode, route identifier and payload with a request line. It expects an acknowledge together with read data and a two-bit response. A bounded wait protects the host from a target that never answers.

Top module: `sb_mailbox`

## Requirements
- R1: After reset every host register reads as zero, the busy flag is clear and no internal request is raised.
- R2: Host word BASE holds the 32-bit target address and word BASE+4 holds the 32-bit data register. In word BASE+8, bits 15:0 are the control/status half: bit 0 is go/busy, bits 2:1 are the completion code and bits 15:8 are the opcode. Bits 31:16 of the same word are the route half: route bits 15:12 are the key and route bits 7:0 are the route identifier. Each written field reads back unchanged while idle.
- R3: A host write to BASE+8 with byte 0 enabled and bit 0 set, while idle, makes busy read 1 from the next cycle until completion. It issues exactly one request carrying the address, opcode, route identifier and data register contents.
- R4: For opcodes 0x06 (register load) and 0x04 (configuration load), the data register holds the target's returned word once busy clears.
- R5: For opcodes 0x07 (register store) and 0x05 (configuration store), the payload sent is the data register value at the time of go, and the data register keeps that value.
- R6: On acknowledge the completion code is the target's two-bit response (0 means success), and busy clears one cycle later.
- R7: If route bits 15:12 are not 0xF at go, the transaction ends one cycle after busy rises with code 2'b10 and no request is issued; this check wins over the opcode check.
- R8: If the opcode is not one of 0x04, 0x05, 0x06, 0x07, the transaction ends one cycle after busy rises with code 2'b11 and no request is issued.
- R9: If no acknowledge arrives within WDOG_CYCLES cycles of request, the request drops after exactly WDOG_CYCLES cycles and the code is 2'b01.
- R10: While busy, host writes to address, data, route and opcode are ignored and a further go is dropped.
- R11: Host writes to status bits 2:1 have no effect; the completion code is cleared when a new transaction starts.
- R12: Once raised, the request and its payload stay stable until acknowledge or timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| host_addr_i | input | 16 | Host byte address (word aligned) |
| host_wen_i | input | 1 | Host write strobe |
| host_be_i | input | 4 | Host byte enables |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data (combinational on address) |
| sb_req_o | output | 1 | Internal request |
| sb_addr_o | output | 32 | Internal target address |
| sb_op_o | output | 8 | Internal opcode |
| sb_route_o | output | 8 | Internal route identifier |
| sb_wdata_o | output | 32 | Internal store payload |
| sb_ack_i | input | 1 | Internal acknowledge |
| sb_rdata_i | input | 32 | Internal returned word |
| sb_resp_i | input | 2 | Internal response code |

## Verification
The bench goes after the two early-exit paths, a bad route key and an unknown opcode, and after the case where both are wrong. A design that issued a request anyway, or that ordered the checks the other way, would show a changed request count or the wrong completion code. A silent target exercises the wait limit: an off-by-one counter gives a request length other than the limit. Host writes landing during that long busy window must leave the address readback and the request count unchanged. A target error response must still deliver the returned word. Attempts to write the completion bits must not change them, and a new start must clear a stale code.

// File: rtl/sb_mbx_pkg.sv
package sb_mbx_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned OP_W    = 8;
    localparam int unsigned ROUTE_W = 16;
    localparam int unsigned RESP_W  = 2;
    localparam int unsigned NBYTE   = WORD_W / 8;

    localparam logic [OP_W-1:0] OPC_CFG_LD = 8'h04;
    localparam logic [OP_W-1:0] OPC_CFG_ST = 8'h05;
    localparam logic [OP_W-1:0] OPC_REG_LD = 8'h06;
    localparam logic [OP_W-1:0] OPC_REG_ST = 8'h07;

    localparam logic [RESP_W-1:0] CODE_OK    = 2'b00;
    localparam logic [RESP_W-1:0] CODE_TMO   = 2'b01;
    localparam logic [RESP_W-1:0] CODE_ROUTE = 2'b10;
    localparam logic [RESP_W-1:0] CODE_BADOP = 2'b11;

    localparam logic [3:0] ROUTE_KEY = 4'hF;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CHECK,
        PH_REQ
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0]  tgt_addr;
        logic [WORD_W-1:0]  data;
        logic [OP_W-1:0]    op;
        logic [ROUTE_W-1:0] route;
        logic               busy;
        logic [RESP_W-1:0]  resp;
        phase_e             phase;
    } mbx_t;

    function automatic logic [WORD_W-1:0] merge_bytes(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [NBYTE-1:0]  be
    );
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int b = 0; b < NBYTE; b++) begin
            if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/sb_mbx_opdec.sv
module sb_mbx_opdec
    import sb_mbx_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output logic            known_o,
    output logic            is_load_o
);
    always_comb begin
        known_o   = 1'b0;
        is_load_o = 1'b0;
        unique case (op_i)
            OPC_CFG_LD, OPC_REG_LD: begin
                known_o   = 1'b1;
                is_load_o = 1'b1;
            end
            OPC_CFG_ST, OPC_REG_ST: known_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sb_mbx_wdog.sv
module sb_mbx_wdog #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic hit_o
);
    localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)           cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign hit_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sb_mbx_hostif.sv
module sb_mbx_hostif
    import sb_mbx_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR = 16'h2330,
    parameter int unsigned NREG      = 3
) (
    input  logic [15:0]        addr_i,
    input  logic               wen_i,
    input  logic [WORD_W-1:0]  word0_i,
    input  logic [WORD_W-1:0]  word1_i,
    input  logic [WORD_W-1:0]  word2_i,
    output logic [NREG-1:0]    we_o,
    output logic [WORD_W-1:0]  rdata_o
);
    logic [NREG-1:0]   hit;
    logic [WORD_W-1:0] words [NREG];

    assign words[0] = word0_i;
    assign words[1] = word1_i;
    assign words[2] = word2_i;

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign hit[g]  = (addr_i == BASE_ADDR + 16'(4 * g));
        assign we_o[g] = wen_i && hit[g];
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) rdata_o = words[i];
        end
    end
endmodule

// File: rtl/sb_mailbox.sv
module sb_mailbox
    import sb_mbx_pkg::*;
#(
    parameter logic [15:0] BASE_ADDR   = 16'h2330,
    parameter int unsigned WDOG_CYCLES = 1024
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [15:0] host_addr_i,
    input  logic        host_wen_i,
    input  logic [3:0]  host_be_i,
    input  logic [31:0] host_wdata_i,
    output logic [31:0] host_rdata_o,
    output logic        sb_req_o,
    output logic [31:0] sb_addr_o,
    output logic [7:0]  sb_op_o,
    output logic [7:0]  sb_route_o,
    output logic [31:0] sb_wdata_o,
    input  logic        sb_ack_i,
    input  logic [31:0] sb_rdata_i,
    input  logic [1:0]  sb_resp_i
);
    localparam int unsigned NREG = 3;

    mbx_t st_d, st_q;

    logic [NREG-1:0]   we;
    logic [WORD_W-1:0] ctl_word;
    logic              op_known, op_load, wd_hit, in_req;

    assign ctl_word = {st_q.route, st_q.op, 5'b0, st_q.resp, st_q.busy};
    assign in_req   = (st_q.phase == PH_REQ);

    sb_mbx_hostif #(.BASE_ADDR(BASE_ADDR), .NREG(NREG)) u_host (
        .addr_i  (host_addr_i),
        .wen_i   (host_wen_i),
        .word0_i (st_q.tgt_addr),
        .word1_i (st_q.data),
        .word2_i (ctl_word),
        .we_o    (we),
        .rdata_o (host_rdata_o)
    );

    sb_mbx_opdec u_dec (
        .op_i      (st_q.op),
        .known_o   (op_known),
        .is_load_o (op_load)
    );

    sb_mbx_wdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (in_req),
        .hit_o  (wd_hit)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (we[0]) st_d.tgt_addr = merge_bytes(st_q.tgt_addr, host_wdata_i, host_be_i);
            if (we[1]) st_d.data     = merge_bytes(st_q.data, host_wdata_i, host_be_i);
            if (we[2]) begin
                if (host_be_i[1]) st_d.op          = host_wdata_i[15:8];
                if (host_be_i[2]) st_d.route[7:0]  = host_wdata_i[23:16];
                if (host_be_i[3]) st_d.route[15:8] = host_wdata_i[31:24];
                if (host_be_i[0] && host_wdata_i[0]) begin
                    st_d.busy  = 1'b1;
                    st_d.resp  = CODE_OK;
                    st_d.phase = PH_CHECK;
                end
            end
        end
        unique case (st_q.phase)
            PH_CHECK: begin
                if (st_q.route[15:12] != ROUTE_KEY) begin
                    st_d.resp  = CODE_ROUTE;
                    st_d.busy  = 1'b0;
                    st_d.phase = PH_IDLE;
                end else if (!op_known) begin
                    st_d.resp  = CODE_BADOP;
                    st_d.busy  = 1'b0;
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.phase = PH_REQ;
                end
            end
            PH_REQ: begin
                if (sb_ack_i) begin
                    st_d.resp  = sb_resp_i;
                    if (op_load) st_d.data = sb_rdata_i;
                    st_d.busy  = 1'b0;
                    st_d.phase = PH_IDLE;
                end else if (wd_hit) begin
                    st_d.resp  = CODE_TMO;
                    st_d.busy  = 1'b0;
                    st_d.phase = PH_IDLE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{tgt_addr: '0, data: '0, op: '0, route: '0,
                      busy: 1'b0, resp: '0, phase: PH_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign sb_req_o   = in_req;
    assign sb_addr_o  = st_q.tgt_addr;
    assign sb_op_o    = st_q.op;
    assign sb_route_o = st_q.route[7:0];
    assign sb_wdata_o = st_q.data;
endmodule

// File: rtl/sb_mailbox_chk.sv
module sb_mailbox_chk #(
    parameter logic [15:0] BASE_ADDR = 16'h2330
) (
    input logic        clk,
    input logic        rst_ni,
    input logic        sb_req,
    input logic        sb_ack,
    input logic [31:0] sb_addr,
    input logic [7:0]  sb_op,
    input logic [31:0] sb_wdata,
    input logic        busy,
    input logic [1:0]  resp,
    input logic        wd_hit,
    input logic        host_wen,
    input logic [15:0] host_addr,
    input logic [31:0] tgt_addr
);
    // R3
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        sb_req |-> busy);

    // R6
    ack_closes_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (sb_req && sb_ack) |=> (!busy && !sb_req));

    // R11
    code_cleared_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(busy) |-> (resp == 2'b00));

    // R12
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (sb_req && !sb_ack && !wd_hit) |=>
            (sb_req && $stable(sb_addr) && $stable(sb_op) && $stable(sb_wdata)));

    // R10
    addr_locked_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (busy && host_wen && host_addr == BASE_ADDR) |=> $stable(tgt_addr));
endmodule

bind sb_mailbox sb_mailbox_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
    .clk       (clk_i),
    .rst_ni    (rst_ni),
    .sb_req    (sb_req_o),
    .sb_ack    (sb_ack_i),
    .sb_addr   (sb_addr_o),
    .sb_op     (sb_op_o),
    .sb_wdata  (sb_wdata_o),
    .busy      (st_q.busy),
    .resp      (st_q.resp),
    .wd_hit    (wd_hit),
    .host_wen  (host_wen_i),
    .host_addr (host_addr_i),
    .tgt_addr  (st_q.tgt_addr)
);

// File: tb/sim_sb_mailbox.sv
module sim_sb_mailbox;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'h2330;
    localparam int WDOG = 1024;
    localparam int NVEC = 7;
    localparam logic [15:0] GOOD_ROUTE = 16'hF03C;

    // {op, addr, wdata, expected data register, forced target response}
    localparam logic [105:0] VEC [NVEC] = '{
        {8'h07, 32'h0000_0010, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'b00},
        {8'h06, 32'h0000_0010, 32'h0000_0000, 32'hDEAD_BEEF, 2'b00},
        {8'h05, 32'h0000_0010, 32'h1234_5678, 32'h1234_5678, 2'b00},
        {8'h04, 32'h0000_0010, 32'h0000_0000, 32'h1234_5678, 2'b00},
        {8'h06, 32'h0000_0014, 32'h0000_0000, 32'hA500_0005, 2'b00},
        {8'h06, 32'h0000_0010, 32'h0000_0000, 32'hDEAD_BEEF, 2'b10},
        {8'h07, 32'h0000_0018, 32'h0BAD_F00D, 32'h0BAD_F00D, 2'b11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] h_addr = '0;
    logic        h_wen = 1'b0;
    logic [3:0]  h_be = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        sb_req;
    logic [31:0] sb_addr, sb_wdata;
    logic [7:0]  sb_op, sb_route;
    logic        ack = 1'b0;
    logic [31:0] t_rdata = '0;
    logic [1:0]  t_resp = '0;

    int tests = 0, fails = 0, cyc = 0;
    logic mute = 1'b0;
    logic [1:0] fresp = '0;
    int dly = 0, req_cycles = 0, req_starts = 0;
    logic req_prev = 1'b0;
    logic [31:0] seen_addr = '0, seen_wdata = '0;
    logic [7:0]  seen_op = '0, seen_route = '0;
    logic [31:0] mem [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    sb_mailbox #(.BASE_ADDR(BASE), .WDOG_CYCLES(WDOG)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .host_addr_i(h_addr), .host_wen_i(h_wen), .host_be_i(h_be),
        .host_wdata_i(h_wdata), .host_rdata_o(h_rdata),
        .sb_req_o(sb_req), .sb_addr_o(sb_addr), .sb_op_o(sb_op),
        .sb_route_o(sb_route), .sb_wdata_o(sb_wdata),
        .sb_ack_i(ack), .sb_rdata_i(t_rdata), .sb_resp_i(t_resp)
    );

    // behavioural internal target
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'hA500_0000 | 32'(i);
            ack <= 1'b0; dly <= 0; req_prev <= 1'b0;
        end else begin
            ack <= 1'b0;
            req_prev <= sb_req;
            if (sb_req) req_cycles <= req_cycles + 1;
            if (sb_req && !req_prev) req_starts <= req_starts + 1;
            if (sb_req && !ack && !mute) begin
                if (dly == 1) begin
                    logic [3:0] idx;
                    idx = {(sb_op == 8'h04 || sb_op == 8'h05), sb_addr[4:2]};
                    ack <= 1'b1; dly <= 0;
                    t_resp <= fresp;
                    t_rdata <= mem[idx];
                    if (sb_op == 8'h07 || sb_op == 8'h05) mem[idx] <= sb_wdata;
                    seen_addr <= sb_addr; seen_op <= sb_op;
                    seen_route <= sb_route; seen_wdata <= sb_wdata;
                end else begin
                    dly <= dly + 1;
                end
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++; tests++;
            $display("FAIL watchdog: act=hung exp=done");
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        h_addr = a; h_be = be; h_wdata = d; h_wen = 1'b1;
        @(negedge clk);
        h_wen = 1'b0; h_be = '0;
    endtask

    task automatic hrd(input logic [15:0] a, output logic [31:0] d);
        h_addr = a;
        #1;
        d = h_rdata;
    endtask

    task automatic setup(input logic [7:0] op, input logic [31:0] a,
                         input logic [31:0] d, input logic [15:0] route);
        hwr(BASE, 4'hF, a);
        hwr(BASE + 16'd4, 4'hF, d);
        hwr(BASE + 16'd8, 4'b1110, {route, op, 8'h00});
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            hrd(BASE + 16'd8, s);
            if (!s[0]) break;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] r, s;
        int starts0, cyc0;
        repeat (3) @(negedge clk);
        // R1 reset state
        hrd(BASE, r);          check("R1 addr", r, 32'h0);
        hrd(BASE + 16'd4, r);  check("R1 data", r, 32'h0);
        hrd(BASE + 16'd8, r);  check("R1 status", r, 32'h0);
        check("R1 req", {31'b0, sb_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 field readback while idle
        hwr(BASE, 4'hF, 32'h1234_5678);
        hrd(BASE, r); check("R2 addr", r, 32'h1234_5678);
        hwr(BASE + 16'd4, 4'b0011, 32'hFFFF_ABCD);
        hrd(BASE + 16'd4, r); check("R2 data bytes", r, 32'h0000_ABCD);
        hwr(BASE + 16'd8, 4'b1110, 32'hF0A5_0600);
        hrd(BASE + 16'd8, r); check("R2 ctl", r, 32'hF0A5_0600);

        // vector table: R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] op; logic [31:0] a, d, e; logic [1:0] fr;
            {op, a, d, e, fr} = VEC[v];
            fresp = fr;
            setup(op, a, d, GOOD_ROUTE);
            starts0 = req_starts;
            hwr(BASE + 16'd8, 4'b0001, 32'h0000_0001);
            hrd(BASE + 16'd8, s); check("R3 busy", {31'b0, s[0]}, 32'h1);
            wait_idle();
            hrd(BASE + 16'd4, r); check("R4/R5 data", r, e);
            hrd(BASE + 16'd8, s); check("R6 code", {30'b0, s[2:1]}, {30'b0, fr});
            check("R3 one request", 32'(req_starts - starts0), 32'h1);
            check("R3 addr", seen_addr, a);
            check("R3 op", {24'b0, seen_op}, {24'b0, op});
            check("R3 route", {24'b0, seen_route}, 32'h3C);
            if (op[0]) check("R5 payload", seen_wdata, d);
        end

        // R7 bad route key, one cycle busy, no request
        setup(8'h06, 32'h10, 32'h0, 16'h0012);
        starts0 = req_starts;
        hwr(BASE + 16'd8, 4'b0001, 32'h1);
        hrd(BASE + 16'd8, s); check("R7 busy one cycle", {31'b0, s[0]}, 32'h1);
        @(negedge clk);
        hrd(BASE + 16'd8, s); check("R7 done", {31'b0, s[0]}, 32'h0);
        check("R7 code", {30'b0, s[2:1]}, 32'h2);
        check("R7 no request", 32'(req_starts - starts0), 32'h0);

        // R8 unknown opcode
        setup(8'h09, 32'h10, 32'h0, GOOD_ROUTE);
        hwr(BASE + 16'd8, 4'b0001, 32'h1);
        @(negedge clk);
        hrd(BASE + 16'd8, s); check("R8 done", {31'b0, s[0]}, 32'h0);
        check("R8 code", {30'b0, s[2:1]}, 32'h3);
        check("R8 no request", 32'(req_starts - starts0), 32'h0);

        // R7 priority over bad opcode
        setup(8'h09, 32'h10, 32'h0, 16'h7012);
        hwr(BASE + 16'd8, 4'b0001, 32'h1);
        @(negedge clk);
        hrd(BASE + 16'd8, s); check("R7 priority code", {30'b0, s[2:1]}, 32'h2);

        // R9 timeout and R10 writes ignored while busy
        mute = 1'b1;
        setup(8'h06, 32'h0000_0020, 32'h5555_AAAA, GOOD_ROUTE);
        cyc0 = req_cycles;
        starts0 = req_starts;
        hwr(BASE + 16'd8, 4'b0001, 32'h1);
        repeat (5) @(negedge clk);
        hwr(BASE, 4'hF, 32'hFFFF_FFFF);
        hwr(BASE + 16'd4, 4'hF, 32'h1111_1111);
        hwr(BASE + 16'd8, 4'hF, 32'h0012_0501);
        wait_idle();
        @(negedge clk);
        hrd(BASE + 16'd8, s); check("R9 code", {30'b0, s[2:1]}, 32'h1);
        check("R9 request length", 32'(req_cycles - cyc0), 32'(WDOG));
        check("R10 one request", 32'(req_starts - starts0), 32'h1);
        hrd(BASE, r); check("R10 addr kept", r, 32'h0000_0020);
        hrd(BASE + 16'd4, r); check("R10 data kept", r, 32'h5555_AAAA);
        check("R10 ctl kept", {s[31:8], 8'h0}, {GOOD_ROUTE, 8'h06, 8'h00});
        mute = 1'b0;

        // R11 host cannot write the code; new start clears it
        hwr(BASE + 16'd8, 4'b0001, 32'h0000_0006);
        hrd(BASE + 16'd8, s); check("R11 code write ignored", {30'b0, s[2:1]}, 32'h1);
        fresp = 2'b00;
        hwr(BASE + 16'd8, 4'b0001, 32'h1);
        hrd(BASE + 16'd8, s); check("R11 cleared at start", {30'b0, s[2:1]}, 32'h0);
        wait_idle();

        finish_run();
    end
endmodule